// File: doc/BRIEF.md
# Proximity Tag Frame Checker

This block sits behind a serial bit decoder for a low-frequency proximity tag. It gathers the decoded bits of one tag frame, starting at the position the decoder marks as a possible frame start. When the frame is complete it checks the whole frame. The frame is 64 bits long. It has a header of nine 1 bits, ten rows of four data bits, each row followed by an even parity bit, a row of four even column parity bits, and a single 0 stop bit.

A frame that passes every check yields its 40 data bits on a single-cycle valid pulse. A frame that fails any check is dropped, and the block pulses an error and a resync request. The decoder then tries its next candidate start position. This matters because a data run of one 1 bit followed by ten or more 0 bits produces the same waveform as a header. A marker that arrives before the current frame is complete discards the partial frame, and assembly starts again from the new bit.

Top module: `tag_frame_checker`

## Requirements
- R1: While rst_ni is low, id_o is zero and id_valid_o, err_o and resync_o are low.
- R2: A bit sampled with bit_valid_i high and start_i low, while no frame is being assembled, is discarded and never produces id_valid_o or err_o.
- R3: On a clock edge where bit_valid_i is low, bit_i and start_i have no effect. Idle cycles between frame bits do not change the result.
- R4: A bit sampled with bit_valid_i and start_i both high is frame bit 0. Frame bits 0 to 8 must be 1. Row r (r = 0..9) occupies frame bits 9+5r to 13+5r: four data bits and then a parity bit that makes the five bits even. Frame bits 59 to 62 are even parity over data column 0 to 3 across all rows. Frame bit 63 must be 0. For a frame that meets all of these, id_valid_o is high for one cycle, two clock edges after frame bit 63 is sampled. In that same cycle id_o holds the 40 data bits, with frame bit 9 in bit 39 and the remaining data bits following in arrival order.
- R5: A frame with any header bit at 0 pulses err_o and resync_o, and id_valid_o stays low.
- R6: A frame in which any row's five bits have odd parity pulses err_o and resync_o for one cycle.
- R7: A frame whose column parity bit does not make its column even pulses err_o and resync_o for one cycle.
- R8: A frame whose stop bit is 1 pulses err_o and resync_o for one cycle.
- R9: id_o changes only in the cycle id_valid_o is high. After a rejected frame it keeps the last accepted identifier.
- R10: A bit sampled with bit_valid_i and start_i high in the middle of a frame drops the partial frame and becomes frame bit 0 of a new frame.
- R11: id_valid_o, err_o and resync_o are each high for one cycle per completed frame. id_valid_o and err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Decoded bit value |
| bit_valid_i | input | 1 | bit_i holds a new bit this cycle |
| start_i | input | 1 | This bit is a candidate frame start |
| id_o | output | 40 | Last accepted identifier, first data bit in MSB |
| id_valid_o | output | 1 | One-cycle pulse: id_o holds a new identifier |
| err_o | output | 1 | One-cycle pulse: completed frame failed a check |
| resync_o | output | 1 | One-cycle pulse: decoder should try the next start |

## Verification
Frames built from all-ones, all-zeros and mixed identifiers show that the bit order and the parity generation are correct. Single-bit corruptions then target the header, a row parity bit, a column parity bit, a data bit and the stop bit. A data-bit flip breaks both a row and a column, while a parity-bit flip breaks only one, so each check is shown to work on its own. Further runs send frame bits with no start marker, frames padded with idle cycles that carry toggling bit and marker values, and a frame cut short by a second marker. These show that idle cycles and unmarked bits are ignored and that a new marker restarts assembly. Outputs are sampled one cycle before, at and one cycle after the expected pulse, which fixes the latency and the pulse width.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int unsigned HDR_LEN_D = 9;
  localparam int unsigned ROWS_D    = 10;
  localparam int unsigned COLS_D    = 4;
endpackage

// File: rtl/tagchk_collect.sv
// Shifts in one frame after a start marker; first bit ends at the MSB.
module tagchk_collect #(
  parameter int unsigned FRAME_LEN = 64,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_i,
  input  logic                 bit_valid_i,
  input  logic                 start_i,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (bit_valid_i) begin
        if (start_i) begin
          // marker wins: drop any partial frame
          frame_o  <= {frame_o[FRAME_LEN-2:0], bit_i};
          cnt_q    <= CNT_W'(1);
          active_q <= 1'b1;
        end else if (active_q) begin
          frame_o <= {frame_o[FRAME_LEN-2:0], bit_i};
          if (cnt_q == CNT_W'(FRAME_LEN-1)) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/tagchk_verify.sv
// Combinational frame checks and data extraction.
module tagchk_verify #(
  parameter int unsigned HDR_LEN   = 9,
  parameter int unsigned ROWS      = 10,
  parameter int unsigned COLS      = 4,
  localparam int unsigned ROW_LEN   = COLS + 1,
  localparam int unsigned FRAME_LEN = HDR_LEN + ROWS*ROW_LEN + COLS + 1,
  localparam int unsigned ID_W      = ROWS*COLS,
  localparam int unsigned CPAR_POS  = HDR_LEN + ROWS*ROW_LEN
) (
  input  logic [FRAME_LEN-1:0] frame_i,
  output logic [ID_W-1:0]      id_o,
  output logic                 ok_o
);
  logic [ROWS-1:0]           row_bad;
  logic [COLS-1:0]           col_bad;
  logic [COLS-1:0][ROWS:0]   col_vec;
  logic                      hdr_ok;
  logic                      stop_ok;

  // frame bit index i lives at frame_i[FRAME_LEN-1-i]
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int unsigned TOP = FRAME_LEN-1-(HDR_LEN + r*ROW_LEN);
    assign row_bad[r] = ^frame_i[TOP -: ROW_LEN];
    for (genvar c = 0; c < COLS; c++) begin : g_bit
      assign id_o[ID_W-1-(r*COLS+c)] = frame_i[TOP-c];
      assign col_vec[c][r]           = frame_i[TOP-c];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_vec[c][ROWS] = frame_i[FRAME_LEN-1-(CPAR_POS+c)];
    assign col_bad[c]       = ^col_vec[c];
  end

  assign hdr_ok  = &frame_i[FRAME_LEN-1 -: HDR_LEN];
  assign stop_ok = ~frame_i[0];
  assign ok_o    = hdr_ok & stop_ok & ~|row_bad & ~|col_bad;
endmodule

// File: rtl/tag_frame_checker.sv
module tag_frame_checker
  import tagchk_pkg::*;
#(
  parameter int unsigned HDR_LEN = HDR_LEN_D,
  parameter int unsigned ROWS    = ROWS_D,
  parameter int unsigned COLS    = COLS_D,
  localparam int unsigned FRAME_LEN = HDR_LEN + ROWS*(COLS+1) + COLS + 1,
  localparam int unsigned ID_W      = ROWS*COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  input  logic            bit_valid_i,
  input  logic            start_i,
  output logic [ID_W-1:0] id_o,
  output logic            id_valid_o,
  output logic            err_o,
  output logic            resync_o
);
  logic [FRAME_LEN-1:0] frame;
  logic                 done;
  logic [ID_W-1:0]      id_c;
  logic                 ok_c;

  tagchk_collect #(.FRAME_LEN(FRAME_LEN)) u_collect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .start_i     (start_i),
    .frame_o     (frame),
    .done_o      (done)
  );

  tagchk_verify #(.HDR_LEN(HDR_LEN), .ROWS(ROWS), .COLS(COLS)) u_verify (
    .frame_i (frame),
    .id_o    (id_c),
    .ok_o    (ok_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o       <= '0;
      id_valid_o <= 1'b0;
      err_o      <= 1'b0;
      resync_o   <= 1'b0;
    end else begin
      id_valid_o <= 1'b0;
      err_o      <= 1'b0;
      resync_o   <= 1'b0;
      if (done) begin
        if (ok_c) begin
          id_o       <= id_c;
          id_valid_o <= 1'b1;
        end else begin
          err_o    <= 1'b1;
          resync_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tag_frame_checker_sva.sv
module tag_frame_checker_sva #(
  parameter int unsigned ID_W = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bit_valid_i,
  input logic [ID_W-1:0] id_o,
  input logic            id_valid_o,
  input logic            err_o,
  input logic            resync_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (id_o == '0 && !id_valid_o && !err_o && !resync_o)
        else $error("R1 outputs not clear in reset");
    end
  end

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_valid_o && err_o));

  a_r11_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |=> !id_valid_o);

  a_r11_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r8_resync_with_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> err_o);

  a_r9_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_o |-> $stable(id_o));

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o || err_o) |-> $past(bit_valid_i, 2));
endmodule

bind tag_frame_checker tag_frame_checker_sva #(.ID_W(ID_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_valid_i (bit_valid_i),
  .id_o        (id_o),
  .id_valid_o  (id_valid_o),
  .err_o       (err_o),
  .resync_o    (resync_o)
);

// File: tb/tag_frame_checker_test.sv
module tag_frame_checker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_valid_i = 1'b0;
  logic        start_i = 1'b0;
  logic [39:0] id_o;
  logic        id_valid_o, err_o, resync_o;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;
  logic [39:0] last_id = '0;

  always #4 clk_i = ~clk_i;

  tag_frame_checker uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .start_i(start_i), .id_o(id_o), .id_valid_o(id_valid_o), .err_o(err_o),
    .resync_o(resync_o)
  );

  // kind: 0 none, 1 header, 2 row parity, 3 column parity, 4 stop, 5 data bit
  // entry = {id[39:0], kind[2:0], idx[3:0], ok}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {40'h123456789A, 3'd0, 4'd0, 1'b1},
    {40'hFFFFFFFFFF, 3'd0, 4'd0, 1'b1},
    {40'h0000000000, 3'd0, 4'd0, 1'b1},
    {40'hA55A0FF0C3, 3'd1, 4'd4, 1'b0},
    {40'h0123456789, 3'd2, 4'd9, 1'b0},
    {40'hDEADBEEF01, 3'd3, 4'd2, 1'b0},
    {40'h8000000001, 3'd4, 4'd0, 1'b0},
    {40'hC0FFEE1234, 3'd5, 4'd11, 1'b0}
  };

  function automatic logic [63:0] mk_frame(input logic [39:0] id);
    logic [63:0] f = '0;
    logic [3:0]  colp = '0;
    for (int i = 0; i < 9; i++) f[63-i] = 1'b1;
    for (int r = 0; r < 10; r++) begin
      logic p = 1'b0;
      for (int c = 0; c < 4; c++) begin
        logic d = id[39-(r*4+c)];
        f[63-(9+r*5+c)] = d;
        p = p ^ d;
        colp[c] = colp[c] ^ d;
      end
      f[63-(9+r*5+4)] = p;
    end
    for (int c = 0; c < 4; c++) f[63-(59+c)] = colp[c];
    f[0] = 1'b0;
    return f;
  endfunction

  function automatic logic [63:0] corrupt(input logic [63:0] f, input int kind, input int idx);
    logic [63:0] g = f;
    case (kind)
      1: g[63-idx] = ~g[63-idx];
      2: g[63-(9+idx*5+4)] = ~g[63-(9+idx*5+4)];
      3: g[63-(59+idx)] = ~g[63-(59+idx)];
      4: g[0] = ~g[0];
      5: g[63-(9+(idx/4)*5+(idx%4))] = ~g[63-(9+(idx/4)*5+(idx%4))];
      default: ;
    endcase
    return g;
  endfunction

  task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // enters and leaves at a negedge
  task automatic send_bit(input logic b, input logic st, input int gaps);
    for (int g = 0; g < gaps; g++) begin
      bit_valid_i = 1'b0;
      bit_i = ~bit_i;
      start_i = 1'b1;
      @(negedge clk_i);
    end
    bit_i = b; start_i = st; bit_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    bit_valid_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic send_frame(input logic [63:0] f, input bit use_start, input int gaps);
    for (int i = 0; i < 64; i++) send_bit(f[63-i], use_start && (i == 0), gaps);
  endtask

  task automatic expect_result(input bit ok, input logic [39:0] id, input string req);
    chk(!id_valid_o && !err_o, {req, " early"}, {id_valid_o, err_o}, 0);
    @(negedge clk_i);
    if (ok) begin
      chk(id_valid_o && !err_o && !resync_o, {req, " valid"}, {id_valid_o, err_o, resync_o}, 3'b100);
      chk(id_o == id, {req, " id"}, id_o, id);
      last_id = id;
    end else begin
      chk(!id_valid_o && err_o && resync_o, {req, " err"}, {id_valid_o, err_o, resync_o}, 3'b011);
      chk(id_o == last_id, "R9 id held", id_o, last_id);
    end
    @(negedge clk_i);
    chk(!id_valid_o && !err_o && !resync_o, "R11 one-cycle pulse", {id_valid_o, err_o, resync_o}, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(id_o == '0 && !id_valid_o && !err_o && !resync_o, "R1 reset", {id_valid_o, err_o, resync_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R4 good frames, R5..R8 single corruptions
    for (int v = 0; v < NV; v++) begin
      logic [63:0] f;
      f = corrupt(mk_frame(VEC[v][47:8]), int'(VEC[v][7:5]), int'(VEC[v][4:1]));
      send_frame(f, 1'b1, 0);
      case (VEC[v][7:5])
        3'd0: expect_result(VEC[v][0], VEC[v][47:8], "R4");
        3'd1: expect_result(VEC[v][0], VEC[v][47:8], "R5");
        3'd2: expect_result(VEC[v][0], VEC[v][47:8], "R6");
        3'd3: expect_result(VEC[v][0], VEC[v][47:8], "R7");
        3'd4: expect_result(VEC[v][0], VEC[v][47:8], "R8");
        default: expect_result(VEC[v][0], VEC[v][47:8], "R6 data");
      endcase
    end

    // R2: a complete good frame with no marker produces nothing
    send_frame(mk_frame(40'h5566778899), 1'b0, 0);
    for (int k = 0; k < 4; k++) begin
      chk(!id_valid_o && !err_o, "R2 unmarked ignored", {id_valid_o, err_o}, 0);
      @(negedge clk_i);
    end
    chk(id_o == last_id, "R2 id unchanged", id_o, last_id);

    // R3: idle cycles with toggling bit and marker between every bit
    send_frame(mk_frame(40'h3C3C96A5E1), 1'b1, 2);
    expect_result(1'b1, 40'h3C3C96A5E1, "R3 gaps");

    // R10: partial frame cut by a new marker
    begin
      logic [63:0] fa;
      fa = mk_frame(40'h1111111111);
      for (int i = 0; i < 30; i++) send_bit(fa[63-i], i == 0, 0);
      chk(!id_valid_o && !err_o, "R10 partial silent", {id_valid_o, err_o}, 0);
      send_frame(mk_frame(40'h9876543210), 1'b1, 0);
      expect_result(1'b1, 40'h9876543210, "R10 restart");
    end

    // R5: header bit 0 clear after a good frame; then a good frame recovers
    send_frame(corrupt(mk_frame(40'h0F0F0F0F0F), 1, 0), 1'b1, 0);
    expect_result(1'b0, 40'h0, "R5 first header bit");
    send_frame(mk_frame(40'h0F0F0F0F0F), 1'b1, 0);
    expect_result(1'b1, 40'h0F0F0F0F0F, "R4 after error");

    finish_run();
  end
endmodule